// File: doc/BRIEF.md
# Microcoded Instruction Control Unit

This unit sequences one instruction at a time for a small 8-bit processor whose instructions are 20 bits wide. When it is free it takes an instruction word, keeps it in a holding register, and exposes the decoded register indices, the shift count, the 8-bit immediate and the 8-bit jump target. It then runs the instruction's short micro-sequence. Each control word comes from an internal ROM that holds a fixed slot of four words per opcode. It does not decode the opcode with gates.

The control words drive the datapath. They select the ALU operation and its second operand, request a register write and its destination, choose the write-back source, strobe memory, and choose how the program counter advances. The ALU result, the store data and the ALU zero flag come back in from the datapath. Memory traffic uses one shared 8-bit bus. A load or store first drives the address with an address-valid strobe. In the next micro-step the unit either drives the store data or asks the memory to return read data. Register index 0 is the constant-zero register, and any write aimed at it is dropped.

Top module: `ucode_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `ready` is 1. Every control output (`alu_sel`, `alu_b_imm`, `reg_we`, `wb_mem`, `wr_idx`, `bus_ale`, `bus_oe`, `mem_rd`, `mem_wr`, `pc_src`, `pc_upd`) and `bus_out` are 0.
- R2: The accepted word splits as follows. Opcode is [19:16], `rs_idx` is [15:12], `rt_idx` is [11:8], the R-format destination is [7:4], `shamt` is [3:0], `imm` is [7:0] and `jtarget` is [15:8]. These outputs hold until the next accepted instruction.
- R3: Register-format operations complete in one step with `alu_b_imm`=0 and `wr_idx` taken from bits [7:4]. Their opcodes and `alu_sel` codes are: add 9→0, sub 10→1, and 1→2, or 8→3, nor 5→4, sll 7→5, srl 2→6.
- R4: Immediate operations complete in one step with `alu_b_imm`=1 and `wr_idx` taken from bits [11:8]. Their opcodes and `alu_sel` codes are: addi 3→0, subi 15→1, andi 6→2, ori 4→3.
- R5: A write whose destination index is 0 is suppressed: `reg_we` stays 0. Whenever `reg_we` is 0, `wr_idx` reads 0.
- R6: A load (opcode 13) or store (opcode 0) takes two steps. The first is the address phase: `bus_ale`=1, `bus_oe`=1, `bus_out`=`addr_in`, `alu_sel`=0 and `alu_b_imm`=1. In the second, a load sets `mem_rd`=1 and `wb_mem`=1 and writes to the register at [11:8]. A store instead sets `mem_wr`=1 and `bus_oe`=1 with `bus_out`=`wdata_in`.
- R7: beq (12) and bneq (11) take one step with `alu_sel`=1 (subtract). `pc_src` is 1 (branch) when `alu_zero` is 1 for beq or 0 for bneq, and 0 (increment) otherwise.
- R8: j (opcode 14) takes one step with `pc_src`=2 (jump) and writes no register.
- R9: Timing is fixed. The first step's controls appear in the cycle after the accepting edge and later steps follow one per cycle. `pc_upd`=1 only in the final step, and `ready` returns to 1 in the cycle after it.
- R10: `issue` while `ready`=0 is ignored. The running sequence and the latched fields are unchanged, and nothing runs after the sequence ends.
- R11: `bus_out` is 0 when the bus is not driven. `mem_rd` and `mem_wr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | New instruction present; taken when `ready` is 1 |
| instr | input | 20 | Instruction word |
| ready | output | 1 | Unit idle, able to take an instruction |
| addr_in | input | 8 | Effective address from the ALU |
| wdata_in | input | 8 | Store data from the register file |
| alu_zero | input | 1 | ALU result-is-zero flag |
| rs_idx | output | 4 | First source register index |
| rt_idx | output | 4 | Second source register index |
| wr_idx | output | 4 | Destination register index, 0 when no write |
| shamt | output | 4 | Shift count |
| imm | output | 8 | Immediate or address offset |
| jtarget | output | 8 | Jump target |
| alu_sel | output | 3 | ALU operation code |
| alu_b_imm | output | 1 | ALU operand B from immediate |
| reg_we | output | 1 | Register write enable |
| wb_mem | output | 1 | Write-back from bus rather than ALU |
| bus_out | output | 8 | Shared address/data bus, outgoing value |
| bus_oe | output | 1 | Unit drives the shared bus |
| bus_ale | output | 1 | Address-valid strobe |
| mem_rd | output | 1 | Memory read in data phase |
| mem_wr | output | 1 | Memory write in data phase |
| pc_src | output | 2 | 0 increment, 1 branch, 2 jump |
| pc_upd | output | 1 | Final step; program counter advances |

## Verification
An instruction offered on a falling edge is accepted on the next rising edge. Its first-step controls are valid from that edge on, its second step (for loads and stores only) one edge later, and `ready` reads 1 one edge after the step that carries `pc_upd`. The bench drives every input on a falling edge and counts the rising edges it waits. It then samples on the following falling edge, so each check lands in the exact cycle in which a result is due and never at a transition. The branch flag is held steady through the sampled step because `pc_src` follows it within that cycle.

// File: rtl/ucp_pkg.sv
package ucp_pkg;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_NOR = 3'd4,
    ALU_SLL = 3'd5,
    ALU_SRL = 3'd6
  } alu_e;

  typedef enum logic [1:0] {
    PCM_SEQ = 2'd0,
    PCM_BEQ = 2'd1,
    PCM_BNE = 2'd2,
    PCM_JMP = 2'd3
  } pcm_e;

  localparam logic [1:0] PC_INC = 2'd0;
  localparam logic [1:0] PC_BR  = 2'd1;
  localparam logic [1:0] PC_JMP = 2'd2;

  // opcode numbering is the encoding the program uses
  localparam logic [3:0] OP_SW   = 4'd0;
  localparam logic [3:0] OP_AND  = 4'd1;
  localparam logic [3:0] OP_SRL  = 4'd2;
  localparam logic [3:0] OP_ADDI = 4'd3;
  localparam logic [3:0] OP_ORI  = 4'd4;
  localparam logic [3:0] OP_NOR  = 4'd5;
  localparam logic [3:0] OP_ANDI = 4'd6;
  localparam logic [3:0] OP_SLL  = 4'd7;
  localparam logic [3:0] OP_OR   = 4'd8;
  localparam logic [3:0] OP_ADD  = 4'd9;
  localparam logic [3:0] OP_SUB  = 4'd10;
  localparam logic [3:0] OP_BNE  = 4'd11;
  localparam logic [3:0] OP_BEQ  = 4'd12;
  localparam logic [3:0] OP_LW   = 4'd13;
  localparam logic [3:0] OP_J    = 4'd14;
  localparam logic [3:0] OP_SUBI = 4'd15;

  typedef struct packed {
    logic last;    // final micro-step of the sequence
    logic we;      // register write requested
    logic dst_rt;  // destination from the I-format field
    logic wb_mem;  // write-back from the bus
    logic b_imm;   // ALU operand B from immediate
    logic ale;     // address phase
    logic rd;      // data phase, read
    logic wr;      // data phase, write
    pcm_e pcm;
    alu_e alu;
  } cw_t;

  function automatic cw_t alu_word(alu_e a, logic use_imm);
    cw_t c;
    c        = '0;
    c.last   = 1'b1;
    c.we     = 1'b1;
    c.dst_rt = use_imm;
    c.b_imm  = use_imm;
    c.alu    = a;
    return c;
  endfunction

  function automatic cw_t cw_of(logic [3:0] op, int st);
    cw_t c;
    c      = '0;
    c.last = 1'b1;  // unreachable slots end the sequence
    if (st == 0) begin
      case (op)
        OP_ADD:  c = alu_word(ALU_ADD, 1'b0);
        OP_SUB:  c = alu_word(ALU_SUB, 1'b0);
        OP_AND:  c = alu_word(ALU_AND, 1'b0);
        OP_OR:   c = alu_word(ALU_OR,  1'b0);
        OP_NOR:  c = alu_word(ALU_NOR, 1'b0);
        OP_SLL:  c = alu_word(ALU_SLL, 1'b0);
        OP_SRL:  c = alu_word(ALU_SRL, 1'b0);
        OP_ADDI: c = alu_word(ALU_ADD, 1'b1);
        OP_SUBI: c = alu_word(ALU_SUB, 1'b1);
        OP_ANDI: c = alu_word(ALU_AND, 1'b1);
        OP_ORI:  c = alu_word(ALU_OR,  1'b1);
        OP_LW, OP_SW: begin
          c.last  = 1'b0;
          c.ale   = 1'b1;
          c.b_imm = 1'b1;
          c.alu   = ALU_ADD;
        end
        OP_BEQ: begin
          c.alu = ALU_SUB;
          c.pcm = PCM_BEQ;
        end
        OP_BNE: begin
          c.alu = ALU_SUB;
          c.pcm = PCM_BNE;
        end
        OP_J:    c.pcm = PCM_JMP;
        default: c.last = 1'b1;
      endcase
    end else if (st == 1) begin
      case (op)
        OP_LW: begin
          c.we     = 1'b1;
          c.dst_rt = 1'b1;
          c.wb_mem = 1'b1;
          c.rd     = 1'b1;
        end
        OP_SW:   c.wr = 1'b1;
        default: c.last = 1'b1;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/ucp_rom.sv
module ucp_rom
  import ucp_pkg::*;
#(
  parameter int OPW = 4,
  parameter int SW  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [OPW+SW-1:0] addr,
  output cw_t               q
);
  localparam int STEPS = 2 ** SW;
  localparam int DEPTH = 2 ** (OPW + SW);

  cw_t mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = cw_of(4'(i / STEPS), i % STEPS);
    end
  end

  // synchronous read; output register cleared when no sequence continues
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= mem[addr];
    end else begin
      q <= '0;
    end
  end
endmodule

// File: rtl/ucp_seq.sv
module ucp_seq #(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          last,
  output logic          busy,
  output logic          rom_en,
  output logic [SW-1:0] step
);
  logic cont;

  assign cont   = busy & ~last;
  assign rom_en = accept | cont;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
    end else begin
      busy <= rom_en;
      if (accept) begin
        step <= SW'(1);
      end else if (cont) begin
        step <= step + SW'(1);
      end else begin
        step <= '0;
      end
    end
  end

  // a sequence never wraps past the last slot of its opcode
  p_step_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |-> (step != '0));
endmodule

// File: rtl/ucp_fields.sv
module ucp_fields #(
  parameter int OPW = 4,
  parameter int RW  = 4,
  parameter int DW  = 8,
  localparam int IW = OPW + 2 * RW + DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [IW-1:0]  instr,
  output logic [OPW-1:0] op,
  output logic [RW-1:0]  rs,
  output logic [RW-1:0]  rt,
  output logic [RW-1:0]  rd,
  output logic [RW-1:0]  sh,
  output logic [DW-1:0]  imm,
  output logic [DW-1:0]  jt
);
  logic [IW-1:0] iq;

  always_ff @(posedge clk) begin
    if (rst) begin
      iq <= '0;
    end else if (load) begin
      iq <= instr;
    end
  end

  assign op  = iq[IW-1 -: OPW];
  assign rs  = iq[IW-OPW-1 -: RW];
  assign rt  = iq[IW-OPW-RW-1 -: RW];
  assign rd  = iq[DW-1 -: RW];
  assign sh  = iq[RW-1:0];
  assign imm = iq[DW-1:0];
  assign jt  = iq[IW-OPW-1 -: DW];
endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
  import ucp_pkg::*;
#(
  parameter int DW  = 8,
  parameter int RW  = 4,
  parameter int OPW = 4,
  parameter int SW  = 2,
  localparam int IW = OPW + 2 * RW + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [IW-1:0] instr,
  output logic          ready,
  input  logic [DW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          alu_zero,
  output logic [RW-1:0] rs_idx,
  output logic [RW-1:0] rt_idx,
  output logic [RW-1:0] wr_idx,
  output logic [RW-1:0] shamt,
  output logic [DW-1:0] imm,
  output logic [DW-1:0] jtarget,
  output logic [2:0]    alu_sel,
  output logic          alu_b_imm,
  output logic          reg_we,
  output logic          wb_mem,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          bus_ale,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [1:0]    pc_src,
  output logic          pc_upd
);
  localparam int AW = OPW + SW;

  cw_t            cw;
  logic           busy, rom_en, accept;
  logic [SW-1:0]  step;
  logic [OPW-1:0] op_q;
  logic [RW-1:0]  rd_q;
  logic [RW-1:0]  wr_sel;
  logic [AW-1:0]  rom_addr;

  assign accept = issue & ~busy;
  assign ready  = ~busy;

  ucp_fields #(.OPW(OPW), .RW(RW), .DW(DW)) u_fields (
    .clk(clk), .rst(rst), .load(accept), .instr(instr),
    .op(op_q), .rs(rs_idx), .rt(rt_idx), .rd(rd_q), .sh(shamt),
    .imm(imm), .jt(jtarget)
  );

  ucp_seq #(.SW(SW)) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .last(cw.last),
    .busy(busy), .rom_en(rom_en), .step(step)
  );

  // first word is read straight from the incoming opcode
  assign rom_addr = accept ? {instr[IW-1 -: OPW], {SW{1'b0}}} : {op_q, step};

  ucp_rom #(.OPW(OPW), .SW(SW)) u_rom (
    .clk(clk), .rst(rst), .en(rom_en), .addr(rom_addr), .q(cw)
  );

  assign wr_sel    = cw.dst_rt ? rt_idx : rd_q;
  assign reg_we    = cw.we & (wr_sel != '0);
  assign wr_idx    = reg_we ? wr_sel : '0;
  assign alu_sel   = cw.alu;
  assign alu_b_imm = cw.b_imm;
  assign wb_mem    = cw.wb_mem;
  assign bus_ale   = cw.ale;
  assign mem_rd    = cw.rd;
  assign mem_wr    = cw.wr;
  assign bus_oe    = cw.ale | cw.wr;
  assign bus_out   = cw.ale ? addr_in : (cw.wr ? wdata_in : '0);
  assign pc_upd    = cw.last;

  always_comb begin
    case (cw.pcm)
      PCM_BEQ: pc_src = alu_zero ? PC_BR : PC_INC;
      PCM_BNE: pc_src = alu_zero ? PC_INC : PC_BR;
      PCM_JMP: pc_src = PC_JMP;
      default: pc_src = PC_INC;
    endcase
  end

  p_zero_guard_r5: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (wr_idx != '0));

  p_addr_then_data_r6: assert property (@(posedge clk) disable iff (rst)
    bus_ale |=> (mem_rd || mem_wr));

  p_strobe_drives_r6: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> (bus_oe && !mem_rd && !mem_wr));

  p_rdwr_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_ready_after_last_r9: assert property (@(posedge clk) disable iff (rst)
    pc_upd |=> ready);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!ready && issue) |=> $stable(rs_idx));
endmodule

// File: tb/sim_ucode_ctrl.sv
`timescale 1ns/1ps
module sim_ucode_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [19:0] instr = '0;
  logic [7:0]  addr_in = 8'h3C;
  logic [7:0]  wdata_in = 8'hC3;
  logic        alu_zero = 1'b0;
  logic        ready, alu_b_imm, reg_we, wb_mem, bus_oe, bus_ale;
  logic        mem_rd, mem_wr, pc_upd;
  logic [3:0]  rs_idx, rt_idx, wr_idx, shamt;
  logic [7:0]  imm, jtarget, bus_out;
  logic [2:0]  alu_sel;
  logic [1:0]  pc_src;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ucode_ctrl u0 (
    .clk(clk), .rst(rst), .issue(issue), .instr(instr), .ready(ready),
    .addr_in(addr_in), .wdata_in(wdata_in), .alu_zero(alu_zero),
    .rs_idx(rs_idx), .rt_idx(rt_idx), .wr_idx(wr_idx), .shamt(shamt),
    .imm(imm), .jtarget(jtarget), .alu_sel(alu_sel), .alu_b_imm(alu_b_imm),
    .reg_we(reg_we), .wb_mem(wb_mem), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_ale(bus_ale), .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_src(pc_src),
    .pc_upd(pc_upd)
  );

  // expected-control packing: alu,bimm,we,wb,wr[4],ale,oe,rd,wr,pc[2],upd
  function automatic logic [16:0] ex(int a, int bi, int we, int wb, int wr,
                                     int ale, int oe, int rd, int wt, int pc, int up);
    return {a[2:0], bi[0], we[0], wb[0], wr[3:0], ale[0], oe[0], rd[0], wt[0],
            pc[1:0], up[0]};
  endfunction

  function automatic logic [19:0] ri(int op, int rs, int rt, int rd, int sh);
    return {op[3:0], rs[3:0], rt[3:0], rd[3:0], sh[3:0]};
  endfunction

  function automatic logic [19:0] ii(int op, int rs, int rt, int im);
    return {op[3:0], rs[3:0], rt[3:0], im[7:0]};
  endfunction

  function automatic logic [55:0] ent(logic [19:0] w, int z, int two,
                                      logic [16:0] e0, logic [16:0] e1);
    return {w, z[0], two[0], e0, e1};
  endfunction

  localparam int NV = 21;
  localparam logic [55:0] VEC [NV] = '{
    ent(ri(9,1,2,3,0),  0, 0, ex(0,0,1,0,3,0,0,0,0,0,1), 17'd0),  // R3 add
    ent(ri(10,2,3,4,0), 0, 0, ex(1,0,1,0,4,0,0,0,0,0,1), 17'd0),  // R3 sub
    ent(ri(1,3,4,5,0),  0, 0, ex(2,0,1,0,5,0,0,0,0,0,1), 17'd0),  // R3 and
    ent(ri(8,4,5,1,0),  0, 0, ex(3,0,1,0,1,0,0,0,0,0,1), 17'd0),  // R3 or
    ent(ri(5,5,1,2,0),  0, 0, ex(4,0,1,0,2,0,0,0,0,0,1), 17'd0),  // R3 nor
    ent(ri(7,1,0,3,4),  0, 0, ex(5,0,1,0,3,0,0,0,0,0,1), 17'd0),  // R3 sll
    ent(ri(2,2,0,4,7),  0, 0, ex(6,0,1,0,4,0,0,0,0,0,1), 17'd0),  // R3 srl
    ent(ri(9,1,2,0,0),  0, 0, ex(0,0,0,0,0,0,0,0,0,0,1), 17'd0),  // R5 rd=0
    ent(ii(3,1,2,8'h7F),0, 0, ex(0,1,1,0,2,0,0,0,0,0,1), 17'd0),  // R4 addi
    ent(ii(15,2,3,8'h01),0,0, ex(1,1,1,0,3,0,0,0,0,0,1), 17'd0),  // R4 subi
    ent(ii(6,3,4,8'hF0),0, 0, ex(2,1,1,0,4,0,0,0,0,0,1), 17'd0),  // R4 andi
    ent(ii(4,4,5,8'h0F),0, 0, ex(3,1,1,0,5,0,0,0,0,0,1), 17'd0),  // R4 ori
    ent(ii(3,1,0,8'h05),0, 0, ex(0,1,0,0,0,0,0,0,0,0,1), 17'd0),  // R5 rt=0
    ent(ii(12,1,2,3),   1, 0, ex(1,0,0,0,0,0,0,0,0,1,1), 17'd0),  // R7 beq taken
    ent(ii(12,1,2,3),   0, 0, ex(1,0,0,0,0,0,0,0,0,0,1), 17'd0),  // R7 beq not
    ent(ii(11,1,2,4),   0, 0, ex(1,0,0,0,0,0,0,0,0,1,1), 17'd0),  // R7 bneq taken
    ent(ii(11,1,2,4),   1, 0, ex(1,0,0,0,0,0,0,0,0,0,1), 17'd0),  // R7 bneq not
    ent(ii(14,10,5,0),  0, 0, ex(0,0,0,0,0,0,0,0,0,2,1), 17'd0),  // R8 j
    ent(ii(13,1,2,4),   0, 1, ex(0,1,0,0,0,1,1,0,0,0,0),
                              ex(0,0,1,1,2,0,0,1,0,0,1)),         // R6 lw
    ent(ii(0,1,3,8),    0, 1, ex(0,1,0,0,0,1,1,0,0,0,0),
                              ex(0,0,0,0,0,0,1,0,1,0,1)),         // R6 sw
    ent(ii(13,1,0,2),   0, 1, ex(0,1,0,0,0,1,1,0,0,0,0),
                              ex(0,0,0,1,0,0,0,1,0,0,1))          // R5 lw rt=0
  };

  function automatic logic [16:0] obs();
    return {alu_sel, alu_b_imm, reg_we, wb_mem, wr_idx, bus_ale, bus_oe,
            mem_rd, mem_wr, pc_src, pc_upd};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_step(input logic [16:0] e, input string req);
    logic [7:0] eb;
    chk(obs() == e, req, {15'd0, obs()}, {15'd0, e});
    eb = e[6] ? addr_in : (e[3] ? wdata_in : 8'h00);
    chk(bus_out == eb, "R11/R6 bus value", {24'd0, bus_out}, {24'd0, eb});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(ready == 1'b1, "R1 ready", {31'd0, ready}, 32'd1);
    chk(obs() == 17'd0 && bus_out == 8'd0, "R1 controls idle",
        {15'd0, obs()}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [19:0] w;
      logic [16:0] e0, e1;
      logic z, two;
      {w, z, two, e0, e1} = VEC[v];
      instr    = w;
      issue    = 1'b1;
      alu_zero = z;
      @(posedge clk);
      @(negedge clk);
      issue = 1'b0;
      chk_step(e0, $sformatf("R9 step0 vector %0d", v));
      // R2 field split
      chk({rs_idx, rt_idx, shamt, imm, jtarget} == {w[15:12], w[11:8], w[3:0], w[7:0], w[15:8]},
          "R2 fields", {4'd0, rs_idx, rt_idx, shamt, imm, jtarget},
          {4'd0, w[15:12], w[11:8], w[3:0], w[7:0], w[15:8]});
      if (two) begin
        @(posedge clk);
        @(negedge clk);
        chk_step(e1, $sformatf("R6 step1 vector %0d", v));
      end
      @(posedge clk);
      @(negedge clk);
      chk(ready == 1'b1 && obs() == 17'd0, "R9 ready after last",
          {14'd0, ready, obs()}, {14'd0, 1'b1, 17'd0});
    end

    // R10: issue during a running load is ignored
    instr = ii(13,3,4,9);
    issue = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instr = ri(9,5,5,5,0);
    issue = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(obs() == ex(0,0,1,1,4,0,0,1,0,0,1), "R10 sequence kept",
        {15'd0, obs()}, {15'd0, ex(0,0,1,1,4,0,0,1,0,0,1)});
    chk(rs_idx == 4'd3 && rt_idx == 4'd4, "R10 fields kept",
        {24'd0, rs_idx, rt_idx}, 32'h34);
    issue = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(ready == 1'b1 && obs() == 17'd0, "R10 ignored word not run",
        {14'd0, ready, obs()}, {14'd0, 1'b1, 17'd0});
    chk(rs_idx == 4'd3, "R10 rs after end", {28'd0, rs_idx}, 32'd3);

    // R1 reset mid-sequence returns to idle
    instr = ii(0,1,3,8);
    issue = 1'b1;
    @(posedge clk);
    @(negedge clk);
    issue = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(ready == 1'b1 && obs() == 17'd0 && bus_out == 8'd0, "R1 reset mid-run",
        {14'd0, ready, obs()}, {14'd0, 1'b1, 17'd0});
    rst = 1'b0;
    @(posedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule